// File: doc/BRIEF.md
# Hazard-Masked Function Unit Issue Picker

This block chooses which function unit receives the instruction presented on its input. Every instruction carries a function-type code, and each type has its own priority picker. Each picker looks only at the units that can execute that type. A unit asks for the instruction when three things hold: it is capable, it is not busy, and it was not handed an instruction in the previous cycle. A per-unit hazard flag removes that unit's request before the priority encoder runs. As a result, a blocked high-priority unit never holds back an eligible lower-priority one.

Each decision is registered. The winning unit sees a one-cycle issue pulse in the cycle after the instruction was presented. The unit is expected to raise its busy flag in the cycle after that. The per-unit selected output is the issue pulse ORed with the busy flag, so register-file port access starts in the issue cycle and lasts until the unit returns to idle. A found flag, registered in step with the issue pulse, reports whether any free unit of the requested type existed. Hazards are not taken into account for found.

Top module: `fuip_issue_picker`

## Requirements
- R1: Function-type codes are 0 = logical (units 0 and 1 capable), 1 = shift (units 1, 2 and 3 capable) and 2 = multiply (units 4 and 5 capable). Only a capable unit can be issued an instruction of a given code.
- R2: If several units are eligible, the one with the lowest index is issued. A unit is eligible when it is capable, not busy, not hazard-flagged, and was not issued in the previous cycle.
- R3: A hazard-flagged unit is never issued. Its flag is removed from the request before priority encoding, so the next eligible higher-index unit wins instead.
- R4: A unit's hazard flag affects only that unit's own request.
- R5: The issue vector is registered. It has at most one bit set, and that bit is set for exactly one cycle: the cycle after the valid instruction was sampled. If valid was low, the issue vector is all zero.
- R6: A unit issued in one cycle is not eligible for the instruction sampled in that same cycle, even while its busy flag is still low.
- R7: Each bit of the selected output equals that unit's issue bit ORed with its busy input.
- R8: Found is registered. It is high in the cycle after a valid instruction for which at least one capable unit was neither busy nor just issued, regardless of hazards. Otherwise it is low.
- R9: While reset is high, the issue vector and found are zero on the following cycle.
- R10: Function-type code 3 has no capable unit. It never produces an issue pulse, and found stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_valid | input | 1 | Instruction present this cycle |
| insn_type | input | TYPE_W | Function-type code of the instruction |
| unit_busy | input | NUM_UNITS | Busy flag from each function unit |
| unit_hazard | input | NUM_UNITS | Per-unit hazard block |
| issue_pulse | output | NUM_UNITS | One-hot, single-cycle issue to the chosen unit |
| unit_selected | output | NUM_UNITS | Register-port grant: issue OR busy |
| fu_found | output | 1 | A free unit of the requested type existed |

## Verification
Several properties are checked by assertions on every cycle. The issue vector is one-hot or zero. No pulse follows an invalid cycle. A hazarded unit is never issued in the following cycle. No unit is pulsed twice in a row. An issue always comes with found. Inside each picker, the grant must be a single requested bit with no lower requested bit, and it must be present whenever any request exists. Other behaviours can only be shown by the bench's sweep over every type code, valid level, busy pattern and hazard pattern, checked against an arithmetic model. These are the capability sets of each type, the lowest-index choice, the exact value of found, and the ORed selected vector.

// File: rtl/fuip_pkg.sv
package fuip_pkg;
  typedef enum logic [1:0] {
    FT_LOGIC = 2'd0,
    FT_SHIFT = 2'd1,
    FT_MUL   = 2'd2,
    FT_NONE  = 2'd3
  } fu_type_e;

  localparam int DEF_UNITS = 6;
  localparam int DEF_TYPES = 3;
  // capability rows, type 0 in the low slice
  localparam logic [DEF_TYPES*DEF_UNITS-1:0] DEF_CAP = {6'b110000, 6'b001110, 6'b000011};
endpackage

// File: rtl/fuip_req_gate.sv
module fuip_req_gate #(
  parameter int NUM_UNITS = 6
) (
  input  logic [NUM_UNITS-1:0] cap,
  input  logic                 valid,
  input  logic [NUM_UNITS-1:0] busy,
  input  logic [NUM_UNITS-1:0] recent,
  input  logic [NUM_UNITS-1:0] hazard,
  output logic [NUM_UNITS-1:0] free,
  output logic [NUM_UNITS-1:0] req
);
  // free: capable, idle and not issued last cycle (busy not yet visible)
  assign free = cap & ~busy & ~recent;
  // hazard masks each unit's own request before priority encoding
  assign req  = free & ~hazard & {NUM_UNITS{valid}};
endmodule

// File: rtl/fuip_prio_pick.sv
module fuip_prio_pick #(
  parameter int NUM_UNITS = 6
) (
  input  logic [NUM_UNITS-1:0] req,
  output logic [NUM_UNITS-1:0] grant
);
  logic [NUM_UNITS:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < NUM_UNITS; i++) begin : g_chain
    assign grant[i]  = req[i] & ~seen[i];
    assign seen[i+1] = seen[i] | req[i];
  end

  // R2: grant is a single requested bit, lowest index, present iff any request
  always_comb begin
    if (!$isunknown(req)) begin
      a_r2_grant_onehot: assert ($onehot0(grant));
      a_r2_grant_subset: assert ((grant & ~req) == '0);
      a_r2_grant_present: assert ((req == '0) == (grant == '0));
      a_r2_lowest_wins: assert (((grant - 1'b1) & req & {NUM_UNITS{grant != '0}}) == '0);
    end
  end
endmodule

// File: rtl/fuip_issue_picker.sv
module fuip_issue_picker #(
  parameter int NUM_UNITS = fuip_pkg::DEF_UNITS,
  parameter int NUM_TYPES = fuip_pkg::DEF_TYPES,
  parameter int TYPE_W    = 2,
  parameter logic [NUM_TYPES*NUM_UNITS-1:0] CAP_MASK = fuip_pkg::DEF_CAP
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 insn_valid,
  input  logic [TYPE_W-1:0]    insn_type,
  input  logic [NUM_UNITS-1:0] unit_busy,
  input  logic [NUM_UNITS-1:0] unit_hazard,
  output logic [NUM_UNITS-1:0] issue_pulse,
  output logic [NUM_UNITS-1:0] unit_selected,
  output logic                 fu_found
);
  logic [NUM_UNITS-1:0] issue_q;
  logic                 found_q;
  logic [NUM_UNITS-1:0] sel_grant;
  logic                 found_nxt;
  logic [NUM_UNITS-1:0] free_v  [NUM_TYPES];
  logic [NUM_UNITS-1:0] req_v   [NUM_TYPES];
  logic [NUM_UNITS-1:0] grant_v [NUM_TYPES];

  // one request gate and one picker per function type
  for (genvar t = 0; t < NUM_TYPES; t++) begin : g_type
    fuip_req_gate #(.NUM_UNITS(NUM_UNITS)) u_gate (
      .cap    (CAP_MASK[t*NUM_UNITS +: NUM_UNITS]),
      .valid  (insn_valid),
      .busy   (unit_busy),
      .recent (issue_q),
      .hazard (unit_hazard),
      .free   (free_v[t]),
      .req    (req_v[t])
    );
    fuip_prio_pick #(.NUM_UNITS(NUM_UNITS)) u_pick (
      .req   (req_v[t]),
      .grant (grant_v[t])
    );
  end

  // route the picker of the decoded type; unknown codes select nothing
  always_comb begin
    sel_grant = '0;
    found_nxt = 1'b0;
    for (int t = 0; t < NUM_TYPES; t++) begin
      if (insn_type == TYPE_W'(t)) begin
        sel_grant = grant_v[t];
        found_nxt = insn_valid && (free_v[t] != '0);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      issue_q <= '0;
      found_q <= 1'b0;
    end else begin
      issue_q <= sel_grant;
      found_q <= found_nxt;
    end
  end

  assign issue_pulse   = issue_q;
  assign fu_found      = found_q;
  assign unit_selected = issue_q | unit_busy;

  a_r5_onehot_issue: assert property (@(posedge clk) disable iff (rst)
    $onehot0(issue_pulse));
  a_r5_idle_no_issue: assert property (@(posedge clk) disable iff (rst)
    !insn_valid |=> (issue_pulse == '0));
  a_r8_issue_has_found: assert property (@(posedge clk) disable iff (rst)
    (issue_pulse != '0) |-> fu_found);
  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_chk
    a_r3_hazard_blocks: assert property (@(posedge clk) disable iff (rst)
      unit_hazard[u] |=> !issue_pulse[u]);
    a_r6_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
      issue_pulse[u] |=> !issue_pulse[u]);
    a_r5_busy_blocks: assert property (@(posedge clk) disable iff (rst)
      unit_busy[u] |=> !issue_pulse[u]);
  end
endmodule

// File: tb/fuip_issue_picker_test.sv
module fuip_issue_picker_test;
  localparam int N = 6;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         insn_valid = 1'b0;
  logic [1:0]   insn_type = 2'd0;
  logic [N-1:0] unit_busy = '0;
  logic [N-1:0] unit_hazard = '0;
  logic [N-1:0] issue_pulse, unit_selected;
  logic         fu_found;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [N-1:0] prev_issue = '0;

  always #5 clk = ~clk;

  fuip_issue_picker uut (
    .clk(clk), .rst(rst), .insn_valid(insn_valid), .insn_type(insn_type),
    .unit_busy(unit_busy), .unit_hazard(unit_hazard),
    .issue_pulse(issue_pulse), .unit_selected(unit_selected), .fu_found(fu_found)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] cap_of(input logic [1:0] t);
    case (t)
      2'd0: cap_of = 6'b000011;
      2'd1: cap_of = 6'b001110;
      2'd2: cap_of = 6'b110000;
      default: cap_of = 6'b000000;
    endcase
  endfunction

  // apply one instruction, then check the registered result after the edge
  task automatic step(input logic v, input logic [1:0] t, input logic [N-1:0] b,
                      input logic [N-1:0] h, input string tag);
    logic [N-1:0] freev, req, exp_iss;
    logic exp_fnd;
    @(negedge clk);
    insn_valid = v; insn_type = t; unit_busy = b; unit_hazard = h;
    freev = cap_of(t) & ~b & ~prev_issue;
    req = v ? (freev & ~h) : '0;
    exp_iss = req & (~req + 1'b1);
    exp_fnd = v && (freev != '0);
    @(posedge clk); #1;
    chk({tag, " issue R1 R2 R3 R4 R5 R6 R10"}, 32'(issue_pulse), 32'(exp_iss));
    chk({tag, " found R8"}, 32'(fu_found), 32'(exp_fnd));
    chk({tag, " selected R7"}, 32'(unit_selected), 32'(exp_iss | b));
    prev_issue = exp_iss;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("reset issue R9", 32'(issue_pulse), 32'd0);
    chk("reset found R9", 32'(fu_found), 32'd0);
    @(negedge clk); rst = 1'b0;

    // directed cases with literal expectations
    step(1'b1, 2'd1, 6'h00, 6'h00, "shift first pick");
    chk("R1 shift lowest is unit1", 32'(issue_pulse), 32'h02);
    step(1'b1, 2'd1, 6'h00, 6'h00, "shift back to back");
    chk("R6 just-issued unit skipped", 32'(issue_pulse), 32'h04);
    step(1'b1, 2'd1, 6'h00, 6'h06, "shift hazard");
    chk("R3 hazard passes to unit3", 32'(issue_pulse), 32'h08);
    step(1'b1, 2'd0, 6'h00, 6'h01, "logic hazard on unit0");
    chk("R4 unit1 still wins", 32'(issue_pulse), 32'h02);
    step(1'b1, 2'd2, 6'h00, 6'h30, "mul all hazarded");
    chk("R8 found despite hazard", 32'(fu_found), 32'd1);
    chk("R3 no issue when all hazarded", 32'(issue_pulse), 32'd0);
    step(1'b1, 2'd3, 6'h00, 6'h00, "code 3");
    chk("R10 no issue for code 3", 32'(issue_pulse), 32'd0);
    step(1'b0, 2'd0, 6'h00, 6'h00, "invalid");
    chk("R5 no issue when invalid", 32'(issue_pulse), 32'd0);
    step(1'b1, 2'd2, 6'h10, 6'h00, "mul busy unit4");
    chk("R7 selected shows busy and issue", 32'(unit_selected), 32'h30);

    // exhaustive sweep
    for (int t = 0; t < 4; t++)
      for (int v = 0; v < 2; v++)
        for (int b = 0; b < 64; b++)
          for (int h = 0; h < 64; h++)
            step(v[0], t[1:0], b[5:0], h[5:0], "sweep");

    // reset mid-stream
    @(negedge clk);
    insn_valid = 1'b1; insn_type = 2'd0; unit_busy = '0; unit_hazard = '0; rst = 1'b1;
    @(posedge clk); #1;
    chk("R9 reset clears issue", 32'(issue_pulse), 32'd0);
    chk("R9 reset clears found", 32'(fu_found), 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule